// File: doc/BRIEF.md
# Voice Playback Trigger Controller

This block sits in front of a voice playback engine. It watches four key inputs, a combined strobe/step input and a halt input. From these it issues start commands, which carry a group number from 1 to 12, and stop requests. A static mode input chooses between two ways of working.

In key mode the four keys are debounced and the stable chord is decoded straight into a group. The strobe input then acts as a single button that steps through the groups in ascending order. In processor mode the strobe latches the key lines on a sample tick and starts the decoded group, and no stepping takes place.

Each group carries three option bits:
- edge or level trigger;
- holdable or not;
- retriggerable or not.

These bits decide what happens when a key is released, when playback ends while a key is still held, and when a new trigger arrives during playback. The engine reports whether it is busy through a playback-active input.

Top module: `voice_trigger_ctrl`

## Requirements
- R1: The key code, written keyIn[3] keyIn[2] keyIn[1] keyIn[0], maps to groups as follows. Single keys: 1000→1, 0100→2, 0010→3, 0001→4. Two adjacent keys: 1100→5, 0110→6, 0011→7, 1001→8. Three keys: 1110→9, 0111→10, 1011→11, 1101→12.
- R2: Any other code (0000, 1010, 0101, 1111) starts no group.
- R3: In key mode, a key code must stay unchanged for 128 sample ticks (DEB_TICKS) while playActive is low before it takes effect. A shorter pulse has no effect.
- R4: While playActive is high, the stable time required becomes 192 sample ticks (RETRIG_TICKS).
- R5: A new trigger that arrives while a group is active is ignored when that group's optRetrig bit (bit g-1 for group g) is 0. When the bit is 1, the new trigger starts the new group at once.
- R6: A level group (optEdge bit 0) that loses its debounced key before it ends raises stopReq for one cycle. An edge group (optEdge bit 1) keeps playing after its key is released.
- R7: When playActive falls while a group's key is still held, a holdable group (optHold bit 1) is started again with the same number. A group that is not holdable is not restarted.
- R8: In key mode each debounced rise of stbIn starts the next group in sequence: 1, 2, …, 12, then 1 again. The sequence starts at 1 after reset.
- R9: In processor mode, when a sample tick sees stbIn high after it was low, the block latches keyIn and starts the decoded group without any debounce.
- R10: In processor mode, changes on keyIn alone start nothing, and repeated strobes of one code start that same group rather than stepping through the sequence.
- R11: While haltIn is high, stopReq is high from the next cycle on and no start is issued. A key held through the halt does not start anything once the halt ends.
- R12: After reset, startPulse, stopReq and groupNum are 0. startPulse lasts one cycle, and groupNum changes only together with startPulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | One-cycle enable at the sample rate |
| cpuMode | input | 1 | Static mode select: 0 = key mode, 1 = processor mode |
| keyIn | input | 4 | Key lines; keyIn[3] is the first key of the code |
| stbIn | input | 1 | Step button in key mode, latch strobe in processor mode |
| haltIn | input | 1 | Immediate stop |
| playActive | input | 1 | Engine busy |
| optEdge | input | 12 | Per-group edge (1) or level (0) trigger |
| optHold | input | 12 | Per-group holdable |
| optRetrig | input | 12 | Per-group retriggerable |
| startPulse | output | 1 | One-cycle start command |
| groupNum | output | 4 | Group number of the latest start |
| stopReq | output | 1 | Stop request |

## Verification
The hardest situation to reach is the debounce window during playback. A new chord has to be held while the engine stays busy, so that the longer 192-tick threshold applies, and the timing has to be sampled on both sides of that boundary. The hold-restart loop is equally hard: playback must end repeatedly while a key stays debounced-high. The bench reaches both with a small engine model. This model raises playActive on every start for a programmable length, long for the retrigger and release cases and short for the hold loop. Random codes in both modes cover the decode map and the rejection of invalid codes.

// File: rtl/vtrig_pkg.sv
package vtrig_pkg;
  localparam int NGRP = 12;
  localparam int GW   = 4;

  typedef logic [GW-1:0] grp_t;

  // strobes from input conditioning to control
  typedef struct packed {
    logic fire;
    grp_t grp;
    logic viaSeq;
  } trigEv_t;

  typedef struct packed {
    logic [3:0] keyCode;
    logic       seqLvl;
    logic       cpuLvl;
  } holdView_t;

  function automatic grp_t codeToGrp(input logic [3:0] c);
    grp_t g;
    case (c)
      4'b1000: g = 4'd1;
      4'b0100: g = 4'd2;
      4'b0010: g = 4'd3;
      4'b0001: g = 4'd4;
      4'b1100: g = 4'd5;
      4'b0110: g = 4'd6;
      4'b0011: g = 4'd7;
      4'b1001: g = 4'd8;
      4'b1110: g = 4'd9;
      4'b0111: g = 4'd10;
      4'b1011: g = 4'd11;
      4'b1101: g = 4'd12;
      default: g = 4'd0;
    endcase
    return g;
  endfunction

  // inverse map, computed from the forward one
  function automatic logic [3:0] grpToCode(input grp_t g);
    logic [3:0] r;
    r = 4'b0000;
    for (int i = 0; i < 16; i++)
      if (g != 4'd0 && codeToGrp(4'(i)) == g) r = 4'(i);
    return r;
  endfunction

  function automatic logic optBit(input logic [NGRP-1:0] v, input grp_t g);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NGRP; i++)
      if (g == grp_t'(i + 1)) r = v[i];
    return r;
  endfunction
endpackage

// File: rtl/vtrig_debounce.sv
module vtrig_debounce #(
  parameter int W    = 4,
  parameter int MAXT = 192,
  localparam int CW  = $clog2(MAXT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic [CW-1:0] thr,
  input  logic [W-1:0]  raw,
  output logic [W-1:0]  stable
);
  logic [W-1:0]  seen;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen   <= '0;
      stable <= '0;
      cnt    <= '0;
    end else if (tick) begin
      if (raw != seen) begin
        seen <= raw;
        cnt  <= '0;
      end else if (raw != stable) begin
        if (cnt + CW'(1) >= thr) begin
          stable <= raw;
          cnt    <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/vtrig_inputs.sv
module vtrig_inputs
  import vtrig_pkg::*;
#(
  parameter int DEB_TICKS    = 128,
  parameter int RETRIG_TICKS = 192,
  localparam int MAXT = (RETRIG_TICKS > DEB_TICKS) ? RETRIG_TICKS : DEB_TICKS,
  localparam int CW   = $clog2(MAXT + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      cpuMode,
  input  logic [3:0] keyIn,
  input  logic      stbIn,
  input  logic      playActive,
  output trigEv_t   ev,
  output holdView_t hv
);
  logic [CW-1:0] thr;
  logic [3:0]    keyStable, keyPrev, keyRaw;
  logic [0:0]    seqStable, seqRaw;
  logic          seqPrev, cpuStb;
  grp_t          seqPtr;
  logic          keyNew, seqRise, cpuRise;
  grp_t          keyGrp, cpuGrp;

  assign thr    = playActive ? CW'(RETRIG_TICKS) : CW'(DEB_TICKS);
  assign keyRaw = cpuMode ? 4'b0000 : keyIn;
  assign seqRaw = cpuMode ? 1'b0 : stbIn;

  vtrig_debounce #(.W(4), .MAXT(MAXT)) u_keyDeb (
    .clk(clk), .rstN(rstN), .tick(sampleTick), .thr(thr),
    .raw(keyRaw), .stable(keyStable));

  vtrig_debounce #(.W(1), .MAXT(MAXT)) u_seqDeb (
    .clk(clk), .rstN(rstN), .tick(sampleTick), .thr(thr),
    .raw(seqRaw), .stable(seqStable));

  assign keyGrp  = codeToGrp(keyStable);
  assign cpuGrp  = codeToGrp(keyIn);
  assign keyNew  = (keyStable != keyPrev) && (keyGrp != 4'd0);
  assign seqRise = seqStable[0] && !seqPrev;
  assign cpuRise = sampleTick && cpuMode && stbIn && !cpuStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyPrev <= '0;
      seqPrev <= 1'b0;
      cpuStb  <= 1'b0;
      seqPtr  <= 4'd1;
      ev      <= '0;
    end else begin
      keyPrev <= keyStable;
      seqPrev <= seqStable[0];
      if (sampleTick) cpuStb <= stbIn && cpuMode;
      ev.fire <= 1'b0;
      if (cpuRise) begin
        if (cpuGrp != 4'd0) begin
          ev.fire   <= 1'b1;
          ev.grp    <= cpuGrp;
          ev.viaSeq <= 1'b0;
        end
      end else if (keyNew) begin
        ev.fire   <= 1'b1;
        ev.grp    <= keyGrp;
        ev.viaSeq <= 1'b0;
      end else if (seqRise) begin
        ev.fire   <= 1'b1;
        ev.grp    <= seqPtr;
        ev.viaSeq <= 1'b1;
        seqPtr    <= (seqPtr == grp_t'(NGRP)) ? 4'd1 : seqPtr + 4'd1;
      end
    end
  end

  assign hv.keyCode = keyStable;
  assign hv.seqLvl  = seqStable[0];
  assign hv.cpuLvl  = cpuStb;
endmodule

// File: rtl/vtrig_control.sv
module vtrig_control
  import vtrig_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpuMode,
  input  logic            haltIn,
  input  logic            playActive,
  input  logic [NGRP-1:0] optEdge,
  input  logic [NGRP-1:0] optHold,
  input  logic [NGRP-1:0] optRetrig,
  input  trigEv_t         ev,
  input  holdView_t       hv,
  output logic            startPulse,
  output grp_t            groupNum,
  output logic            stopReq
);
  grp_t actGrp;
  logic actSeq, busyPrev, heldNow, isActive;

  assign isActive = (actGrp != 4'd0);

  always_comb begin
    if (cpuMode)     heldNow = hv.cpuLvl;
    else if (actSeq) heldNow = hv.seqLvl;
    else             heldNow = isActive && (hv.keyCode == grpToCode(actGrp));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPulse <= 1'b0;
      stopReq    <= 1'b0;
      groupNum   <= '0;
      actGrp     <= '0;
      actSeq     <= 1'b0;
      busyPrev   <= 1'b0;
    end else begin
      startPulse <= 1'b0;
      stopReq    <= 1'b0;
      busyPrev   <= playActive;
      if (haltIn) begin
        stopReq <= 1'b1;
        actGrp  <= '0;
        actSeq  <= 1'b0;
      end else if (ev.fire && (!isActive || optBit(optRetrig, actGrp))) begin
        startPulse <= 1'b1;
        groupNum   <= ev.grp;
        actGrp     <= ev.grp;
        actSeq     <= ev.viaSeq;
      end else if (isActive && !optBit(optEdge, actGrp) && !heldNow) begin
        stopReq <= 1'b1;
        actGrp  <= '0;
        actSeq  <= 1'b0;
      end else if (isActive && busyPrev && !playActive) begin
        if (optBit(optHold, actGrp) && heldNow) begin
          startPulse <= 1'b1;
        end else begin
          actGrp <= '0;
          actSeq <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/voice_trigger_ctrl.sv
module voice_trigger_ctrl
  import vtrig_pkg::*;
#(
  parameter int DEB_TICKS    = 128,
  parameter int RETRIG_TICKS = 192
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleTick,
  input  logic        cpuMode,
  input  logic [3:0]  keyIn,
  input  logic        stbIn,
  input  logic        haltIn,
  input  logic        playActive,
  input  logic [11:0] optEdge,
  input  logic [11:0] optHold,
  input  logic [11:0] optRetrig,
  output logic        startPulse,
  output logic [3:0]  groupNum,
  output logic        stopReq
);
  trigEv_t   ev;
  holdView_t hv;

  vtrig_inputs #(.DEB_TICKS(DEB_TICKS), .RETRIG_TICKS(RETRIG_TICKS)) u_inputs (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .cpuMode(cpuMode),
    .keyIn(keyIn), .stbIn(stbIn), .playActive(playActive), .ev(ev), .hv(hv));

  vtrig_control u_control (
    .clk(clk), .rstN(rstN), .cpuMode(cpuMode), .haltIn(haltIn),
    .playActive(playActive), .optEdge(optEdge), .optHold(optHold),
    .optRetrig(optRetrig), .ev(ev), .hv(hv), .startPulse(startPulse),
    .groupNum(groupNum), .stopReq(stopReq));
endmodule

// File: rtl/vtrig_checker.sv
module vtrig_checker (
  input logic       clk,
  input logic       rstN,
  input logic       haltIn,
  input logic       startPulse,
  input logic       stopReq,
  input logic [3:0] groupNum
);
  a_r11_halt_stops: assert property (@(posedge clk) disable iff (!rstN)
    haltIn |=> stopReq);

  a_r11_no_start_in_halt: assert property (@(posedge clk) disable iff (!rstN)
    haltIn |=> !startPulse);

  a_r1_group_range: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (groupNum >= 4'd1 && groupNum <= 4'd12));

  a_r12_group_only_on_start: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(groupNum) |-> startPulse);

  a_r6_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(startPulse && stopReq));
endmodule

bind voice_trigger_ctrl vtrig_checker u_vtrigChecker (
  .clk(clk), .rstN(rstN), .haltIn(haltIn), .startPulse(startPulse),
  .stopReq(stopReq), .groupNum(groupNum));

// File: tb/test_voice_trigger_ctrl.sv
module test_voice_trigger_ctrl;
  localparam int TDIV = 4;

  logic clk = 1'b0, rstN = 1'b0, sampleTick = 1'b0, cpuMode = 1'b0;
  logic [3:0] keyIn = 4'b0;
  logic stbIn = 1'b0, haltIn = 1'b0, playActive = 1'b0;
  logic [11:0] optEdge = '1, optHold = '0, optRetrig = '0;
  logic startPulse, stopReq;
  logic [3:0] groupNum;

  int checks = 0, errors = 0;
  int starts = 0, stops = 0, lastGrp = 0, playLen = 20, remain = 0;
  logic prevStop = 1'b0;

  always #2.5 clk = ~clk;

  voice_trigger_ctrl i_voice_trigger_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .cpuMode(cpuMode),
    .keyIn(keyIn), .stbIn(stbIn), .haltIn(haltIn), .playActive(playActive),
    .optEdge(optEdge), .optHold(optHold), .optRetrig(optRetrig),
    .startPulse(startPulse), .groupNum(groupNum), .stopReq(stopReq));

  // tick generator plus engine model, all at the falling edge
  initial begin
    int div;
    div = 0;
    forever begin
      @(negedge clk);
      sampleTick = (div == 0);
      div = (div == TDIV - 1) ? 0 : div + 1;
      if (stopReq && !prevStop) stops++;
      prevStop = stopReq;
      if (startPulse) begin
        starts++;
        lastGrp = groupNum;
        playActive = 1'b1;
        remain = playLen;
      end else if (stopReq) begin
        playActive = 1'b0;
        remain = 0;
      end else if (remain > 0) begin
        remain--;
        if (remain == 0) playActive = 1'b0;
      end
    end
  end

  function automatic int expGroup(input logic [3:0] c);
    case (c)
      4'b1000: return 1;  4'b0100: return 2;  4'b0010: return 3;
      4'b0001: return 4;  4'b1100: return 5;  4'b0110: return 6;
      4'b0011: return 7;  4'b1001: return 8;  4'b1110: return 9;
      4'b0111: return 10; 4'b1011: return 11; 4'b1101: return 12;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rstN = 1'b0; cpuMode = mode; keyIn = 0; stbIn = 0; haltIn = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic haltPulse();
    haltIn = 1'b1;
    repeat (3) @(negedge clk);
    haltIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int s0, st0;
    logic [3:0] c;
    void'($urandom(32'd4321));
    doReset(1'b0);
    // R12 reset state
    check(startPulse == 0 && stopReq == 0 && groupNum == 0, "R12 reset", groupNum, 0);

    // R1 every code in key mode, edge groups
    optEdge = '1; optHold = '0; optRetrig = '0; playLen = 20;
    for (int g = 0; g < 16; g++) begin
      c = 4'(g);
      if (expGroup(c) != 0) begin
        s0 = starts;
        keyIn = c; waitTicks(135);
        check(starts == s0 + 1 && lastGrp == expGroup(c), "R1 decode", lastGrp, expGroup(c));
        keyIn = 0; waitTicks(135);
      end
    end

    // R2 invalid codes
    foreach (c[i]) ;
    s0 = starts;
    keyIn = 4'b1010; waitTicks(140); keyIn = 0; waitTicks(140);
    keyIn = 4'b0101; waitTicks(140); keyIn = 0; waitTicks(140);
    keyIn = 4'b1111; waitTicks(140); keyIn = 0; waitTicks(140);
    check(starts == s0, "R2 invalid", starts - s0, 0);

    // R1/R2 random codes
    for (int k = 0; k < 8; k++) begin
      c = 4'($urandom % 16);
      s0 = starts;
      keyIn = c; waitTicks(135); keyIn = 0; waitTicks(135);
      check(starts == s0 + ((expGroup(c) != 0) ? 1 : 0), "R2 random count", starts - s0, expGroup(c) != 0);
      if (expGroup(c) != 0) check(lastGrp == expGroup(c), "R1 random", lastGrp, expGroup(c));
    end

    // R3 debounce boundary and glitch
    s0 = starts;
    keyIn = 4'b0001; waitTicks(60); keyIn = 0; waitTicks(200);
    check(starts == s0, "R3 glitch", starts - s0, 0);
    keyIn = 4'b0001; waitTicks(120);
    check(starts == s0, "R3 early", starts - s0, 0);
    waitTicks(15);
    check(starts == s0 + 1, "R3 late", starts - s0, 1);
    keyIn = 0; waitTicks(140);

    // R4 and R5: retrigger with longer debounce while playing
    playLen = 6000; optRetrig = 12'b0000_0000_0001;
    s0 = starts;
    keyIn = 4'b1000; waitTicks(135);
    keyIn = 4'b0100; waitTicks(180);
    check(starts == s0 + 1, "R4 early", starts - s0, 1);
    waitTicks(20);
    check(starts == s0 + 2 && lastGrp == 2, "R5 retrig start", lastGrp, 2);
    check(groupNum == 2, "R12 group held", groupNum, 2);
    haltPulse(); keyIn = 0; waitTicks(140);

    // R5 non-retriggerable ignores
    optRetrig = '0;
    s0 = starts;
    keyIn = 4'b1000; waitTicks(135);
    keyIn = 4'b0100; waitTicks(250);
    check(starts == s0 + 1 && lastGrp == 1, "R5 no retrig", lastGrp, 1);
    haltPulse(); keyIn = 0; waitTicks(140);

    // R6 level release stops, edge does not
    optEdge = 12'b1111_1111_1011;
    s0 = starts; st0 = stops;
    keyIn = 4'b0010; waitTicks(135);
    keyIn = 0; waitTicks(200);
    check(stops == st0 + 1 && starts == s0 + 1, "R6 level stop", stops - st0, 1);
    optEdge = '1;
    st0 = stops;
    keyIn = 4'b0010; waitTicks(135);
    keyIn = 0; waitTicks(200);
    check(stops == st0 && playActive == 1, "R6 edge plays on", stops - st0, 0);
    haltPulse(); waitTicks(140);

    // R7 hold restart vs unholdable
    playLen = 40; optHold = 12'b0000_0000_1000;
    s0 = starts;
    keyIn = 4'b0001; waitTicks(135 + 100);
    check(starts >= s0 + 3 && lastGrp == 4, "R7 holdable restarts", starts - s0, 3);
    keyIn = 0; waitTicks(260);
    s0 = starts;
    waitTicks(50);
    check(starts == s0, "R7 stops after release", starts - s0, 0);
    optHold = '0;
    keyIn = 4'b0001; waitTicks(235);
    check(starts == s0 + 1, "R7 unholdable once", starts - s0, 1);
    keyIn = 0; waitTicks(200);

    // R11 halt
    playLen = 6000;
    keyIn = 4'b0100; waitTicks(135);
    haltIn = 1'b1;
    @(negedge clk);
    check(stopReq == 1, "R11 stop next cycle", stopReq, 1);
    s0 = starts;
    keyIn = 4'b0010; waitTicks(140);
    check(stopReq == 1 && starts == s0, "R11 halt blocks", starts - s0, 0);
    haltIn = 1'b0; waitTicks(50);
    check(starts == s0, "R11 held key after halt", starts - s0, 0);
    keyIn = 0; waitTicks(200);

    // R8 sequential stepping with wrap
    playLen = 20;
    doReset(1'b0);
    for (int n = 0; n < 13; n++) begin
      s0 = starts;
      stbIn = 1; waitTicks(135);
      check(starts == s0 + 1 && lastGrp == (n % 12) + 1, "R8 sequence", lastGrp, (n % 12) + 1);
      stbIn = 0; waitTicks(135);
    end

    // R9/R10 processor mode
    doReset(1'b1);
    playLen = 8;
    s0 = starts;
    keyIn = 4'b1100; waitTicks(200);
    check(starts == s0, "R10 keys alone", starts - s0, 0);
    for (int k = 0; k < 24; k++) begin
      c = (k < 3) ? 4'b1110 : 4'($urandom % 16);
      keyIn = c; waitTicks(2);
      s0 = starts;
      stbIn = 1; waitTicks(3); stbIn = 0; waitTicks(4);
      check(starts == s0 + ((expGroup(c) != 0) ? 1 : 0), "R9 strobe count", starts - s0, expGroup(c) != 0);
      if (expGroup(c) != 0) check(lastGrp == expGroup(c), "R10 strobe group", lastGrp, expGroup(c));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule